// File: doc/BRIEF.md
# Strided Row Loader into a 2D Word Scratchpad

This block moves rows of 32-bit words from a byte-addressed system memory read port into a local scratchpad organised as 64 rows by 16 columns of 32-bit words. Software first writes a 32-bit setup word. The setup word gives the element width, the stride between rows in memory, the number of words per row, the number of rows, the row step on the scratchpad side, a horizontal or vertical placement flag and the starting scratchpad coordinate. Writing the start bus address then launches the copy.

The engine asks for one word at a time over a valid/ready request channel and waits for a single-cycle data-valid return before it asks for the next word. In vertical placement the words of a row run down one column. In horizontal placement they run along a row and continue into the next row. A busy flag and a wait handshake let software poll for completion or stall on it. The scratchpad has a combinational read port so that its contents can be inspected.

Top module: `sld_top`

## Requirements
- R1: After reset, busy_o is 0, mem_req_valid_o is 0, and wait_ack_o follows wait_req_i.
- R2: A setup write takes effect only when bit 31 is 1 and bits 30:28 are 000. Any other setup write is ignored and the previous setup stays in force.
- R3: A start write while idle launches a transfer. busy_o is 1 from the next cycle and stays 1 until the cycle after the last word is written, when it returns to 0.
- R4: Word e of memory row r is requested at base + r*pitch + 4*e. The pitch in bytes is 8 shifted left by bits 27:24, except that code 0 gives 128.
- R5: The row length is bits 23:20 and the row count is bits 19:16, where 0 means 16 in both fields. Exactly length*count requests are issued.
- R6: The start column X is bits 3:0 and the start row Y is bits 10:4 taken modulo 64. Each new row starts at the previous row's start Y plus the step in bits 15:12 (0 means 16), modulo 64.
- R7: With bit 11 set (vertical), word e of a row is written at row (Yrow + e) mod 64, column X.
- R8: With bit 11 clear (horizontal), word e of a row is written at linear index (Yrow*16 + X + e) mod 1024, where the row is index/16 and the column is index mod 16.
- R9: Only one request is outstanding at a time. A request holds its valid and address until accepted, and no new request is issued before the return for the previous one.
- R10: A start write while busy is ignored. The running transfer keeps its addresses and no extra transfer follows.
- R11: wait_ack_o is 1 exactly when wait_req_i is 1 and busy_o is 0.
- R12: Setup word 0x8304080f places four consecutive 16-word vectors, read from consecutive memory words, down column 15, rows 0 to 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_we_i | input | 1 | Setup word write strobe |
| setup_data_i | input | 32 | Setup word |
| start_we_i | input | 1 | Start address write strobe (launches) |
| start_addr_i | input | ADDR_W | Memory byte address of the first row |
| busy_o | output | 1 | Transfer in progress |
| wait_req_i | input | 1 | Wait request from software |
| wait_ack_o | output | 1 | Wait completion, asserted while requested and idle |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory read request accepted |
| mem_req_addr_o | output | ADDR_W | Memory read byte address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | DATA_W | Read data |
| sp_rd_row_i | input | log2(SP_ROWS) | Scratchpad read row |
| sp_rd_col_i | input | log2(SP_COLS) | Scratchpad read column |
| sp_rd_data_o | output | DATA_W | Scratchpad read data |

## Verification
A wrong row or word counter shows up on the next request as a wrong address on mem_req_addr_o, or as the wrong number of requests, which is visible within one handshake. A wrong scratchpad coordinate only shows once the transfer ends, as a misplaced word seen through the read port. Because the memory returns data derived from each address, every misplaced or misaddressed word is detectable. A faulty state machine shows as busy_o falling on a cycle other than the one after the final return, or as wait_ack_o rising early.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int DESC_W = 32;

  typedef struct packed {
    logic       vert;
    logic [3:0] mpitch;
    logic [3:0] rowlen;
    logic [3:0] nrows;
    logic [3:0] vpitch;
    logic [6:0] y0;
    logic [3:0] x0;
  } sld_desc_t;

  function automatic logic sld_accept(input logic [DESC_W-1:0] w);
    return w[31] && (w[30:28] == 3'b000);
  endfunction

  function automatic sld_desc_t sld_decode(input logic [DESC_W-1:0] w);
    sld_desc_t d;
    d.mpitch = w[27:24];
    d.rowlen = w[23:20];
    d.nrows  = w[19:16];
    d.vpitch = w[15:12];
    d.vert   = w[11];
    d.y0     = w[10:4];
    d.x0     = w[3:0];
    return d;
  endfunction

  // 0 encodes 16 for length, count and scratchpad step
  function automatic logic [4:0] sld_count(input logic [3:0] f);
    return (f == 4'd0) ? 5'd16 : {1'b0, f};
  endfunction
endpackage

// File: rtl/sld_desc_reg.sv
module sld_desc_reg
  import sld_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DESC_W-1:0] data_i,
  output sld_desc_t         desc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           desc_o <= '0;
    else if (we_i && sld_accept(data_i))   desc_o <= sld_decode(data_i);
  end
endmodule

// File: rtl/sld_ctrl.sv
module sld_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic last_i,
  input  logic req_ready_i,
  input  logic rsp_valid_i,
  output logic busy_o,
  output logic req_valid_o,
  output logic start_o,
  output logic step_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} st_e;
  st_e st_q, st_d;

  assign busy_o      = (st_q != ST_IDLE);
  assign req_valid_o = (st_q == ST_REQ);
  assign start_o     = launch_i && (st_q == ST_IDLE);
  assign step_o      = (st_q == ST_RSP) && rsp_valid_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (launch_i)    st_d = ST_REQ;
      ST_REQ:  if (req_ready_i) st_d = ST_RSP;
      ST_RSP:  if (rsp_valid_i) st_d = last_i ? ST_IDLE : ST_REQ;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && last_i) |=> !busy_o);  // R3

  AST_REQ_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i) |=> (!req_valid_o && busy_o));  // R9
endmodule

// File: rtl/sld_agen.sv
module sld_agen
  import sld_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SP_ROWS = 64,
  parameter int SP_COLS = 16,
  localparam int Y_W = $clog2(SP_ROWS),
  localparam int X_W = $clog2(SP_COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sld_desc_t         desc_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [Y_W-1:0]    sp_y_o,
  output logic [X_W-1:0]    sp_x_o,
  output logic              last_o
);
  localparam int CELLS = SP_ROWS * SP_COLS;

  sld_desc_t         d_q;
  logic [ADDR_W-1:0] row_addr_q;
  logic [4:0]        elem_q, row_q;
  logic [Y_W-1:0]    row_y_q;

  logic [4:0]        len, rows, vstep;
  logic [ADDR_W-1:0] pitch;
  logic [X_W-1:0]    x0;
  logic              row_end;
  logic [31:0]       lin;

  always_comb begin
    len     = sld_count(d_q.rowlen);
    rows    = sld_count(d_q.nrows);
    vstep   = sld_count(d_q.vpitch);
    pitch   = (d_q.mpitch == 4'd0) ? ADDR_W'(128) : (ADDR_W'(8) << d_q.mpitch);
    x0      = X_W'(32'(d_q.x0) % SP_COLS);
    row_end = (elem_q == len - 5'd1);
    last_o  = row_end && (row_q == rows - 5'd1);
    mem_addr_o = row_addr_q + ADDR_W'({elem_q, 2'b00});
    lin     = (32'(row_y_q) * SP_COLS + 32'(x0) + 32'(elem_q)) % CELLS;
  end

  // placement variant: down a column, or along rows with carry into Y
  always_comb begin
    if (d_q.vert) begin
      sp_y_o = Y_W'((32'(row_y_q) + 32'(elem_q)) % SP_ROWS);
      sp_x_o = x0;
    end else begin
      sp_y_o = Y_W'(lin / SP_COLS);
      sp_x_o = X_W'(lin % SP_COLS);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q        <= '0;
      row_addr_q <= '0;
      elem_q     <= '0;
      row_q      <= '0;
      row_y_q    <= '0;
    end else if (start_i) begin
      d_q        <= desc_i;
      row_addr_q <= base_i;
      elem_q     <= '0;
      row_q      <= '0;
      row_y_q    <= Y_W'(32'(desc_i.y0) % SP_ROWS);
    end else if (step_i) begin
      if (row_end) begin
        elem_q     <= '0;
        row_q      <= row_q + 5'd1;
        row_addr_q <= row_addr_q + pitch;
        row_y_q    <= Y_W'((32'(row_y_q) + 32'(vstep)) % SP_ROWS);
      end else begin
        elem_q <= elem_q + 5'd1;
      end
    end
  end
endmodule

// File: rtl/sld_spad.sv
module sld_spad #(
  parameter int DATA_W  = 32,
  parameter int SP_ROWS = 64,
  parameter int SP_COLS = 16,
  localparam int Y_W = $clog2(SP_ROWS),
  localparam int X_W = $clog2(SP_COLS)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [Y_W-1:0]    wy_i,
  input  logic [X_W-1:0]    wx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [Y_W-1:0]    ry_i,
  input  logic [X_W-1:0]    rx_i,
  output logic [DATA_W-1:0] rdata_o
);
  // row/column sizes are powers of two, so {y,x} is the flat index
  logic [DATA_W-1:0] mem_q [2**(Y_W+X_W)];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[{wy_i, wx_i}] <= wdata_i;
  end

  assign rdata_o = mem_q[{ry_i, rx_i}];
endmodule

// File: rtl/sld_top.sv
module sld_top
  import sld_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int SP_ROWS = 64,
  parameter int SP_COLS = 16,
  localparam int Y_W = $clog2(SP_ROWS),
  localparam int X_W = $clog2(SP_COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              setup_we_i,
  input  logic [DESC_W-1:0] setup_data_i,
  input  logic              start_we_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic              busy_o,
  input  logic              wait_req_i,
  output logic              wait_ack_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i,
  input  logic [Y_W-1:0]    sp_rd_row_i,
  input  logic [X_W-1:0]    sp_rd_col_i,
  output logic [DATA_W-1:0] sp_rd_data_o
);
  sld_desc_t      desc;
  logic           start, step, last;
  logic [Y_W-1:0] wy;
  logic [X_W-1:0] wx;

  sld_desc_reg u_desc (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(setup_we_i), .data_i(setup_data_i), .desc_o(desc)
  );

  sld_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(start_we_i), .last_i(last),
    .req_ready_i(mem_req_ready_i), .rsp_valid_i(mem_rsp_valid_i),
    .busy_o(busy_o), .req_valid_o(mem_req_valid_o), .start_o(start), .step_o(step)
  );

  sld_agen #(.ADDR_W(ADDR_W), .SP_ROWS(SP_ROWS), .SP_COLS(SP_COLS)) u_agen (
    .clk_i(clk_i), .rst_ni(rst_ni), .desc_i(desc), .start_i(start), .base_i(start_addr_i),
    .step_i(step), .mem_addr_o(mem_req_addr_o), .sp_y_o(wy), .sp_x_o(wx), .last_o(last)
  );

  sld_spad #(.DATA_W(DATA_W), .SP_ROWS(SP_ROWS), .SP_COLS(SP_COLS)) u_spad (
    .clk_i(clk_i), .we_i(step), .wy_i(wy), .wx_i(wx), .wdata_i(mem_rsp_data_i),
    .ry_i(sp_rd_row_i), .rx_i(sp_rd_col_i), .rdata_o(sp_rd_data_o)
  );

  assign wait_ack_o = wait_req_i && !busy_o;

  AST_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_we_i) |=> (busy_o && mem_req_valid_o && mem_req_addr_o == $past(start_addr_i)));  // R3

  AST_HOLD_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));  // R9

  AST_IGNORE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_we_i && mem_req_valid_o && !mem_req_ready_i) |=> $stable(mem_req_addr_o));  // R10

  AST_WAIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_ack_o |-> !busy_o);  // R11
endmodule

// File: tb/sld_top_test.sv
module sld_top_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        setup_we = 1'b0;
  logic [31:0] setup_data = '0;
  logic        start_we = 1'b0;
  logic [31:0] start_addr = '0;
  logic        busy;
  logic        wait_req = 1'b0;
  logic        wait_ack;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [5:0]  rd_row = '0;
  logic [3:0]  rd_col = '0;
  logic [31:0] rd_data;

  sld_top uut (
    .clk_i(clk), .rst_ni(rst_ni), .setup_we_i(setup_we), .setup_data_i(setup_data),
    .start_we_i(start_we), .start_addr_i(start_addr), .busy_o(busy),
    .wait_req_i(wait_req), .wait_ack_o(wait_ack),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready), .mem_req_addr_o(req_addr),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
    .sp_rd_row_i(rd_row), .sp_rd_col_i(rd_col), .sp_rd_data_o(rd_data)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  initial forever begin @(posedge clk); cyc++; end

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ {a[15:0], a[31:16]} ^ 32'h3C5A_96E1;
  endfunction

  // memory model
  int          req_gap = 0, rsp_gap = 0, req_wait = 0, rsp_wait = 0;
  logic        pend = 1'b0;
  logic [31:0] cap = '0;
  int          n_req = 0, rsp_cyc = 0;
  logic [31:0] req_log [512];

  initial begin
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (req_ready) begin
        req_ready = 1'b0; pend = 1'b1; rsp_wait = rsp_gap;
      end else if (pend) begin
        if (rsp_wait == 0) begin
          rsp_valid = 1'b1; rsp_data = pat(cap); pend = 1'b0; rsp_cyc = cyc;
        end else rsp_wait--;
      end else if (rst_ni && req_valid) begin
        if (req_wait < req_gap) req_wait++;
        else begin
          req_wait = 0; req_ready = 1'b1; cap = req_addr;
          if (n_req < 512) req_log[n_req] = cap;
          n_req++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bench copy of the accepted setup (R2)
  logic [31:0] cur = '0;
  logic [31:0] shadow [1024];
  bit          sh_vld [1024];

  function automatic logic [31:0] mk(input bit v, input int mp, input int rl, input int nr,
                                     input int vp, input int y, input int x);
    return {1'b1, 3'b000, 4'(mp), 4'(rl), 4'(nr), 4'(vp), v, 7'(y), 4'(x)};
  endfunction

  task automatic write_setup(input logic [31:0] w);
    @(negedge clk); setup_we = 1'b1; setup_data = w;
    @(negedge clk); setup_we = 1'b0;
    if (w[31] && w[30:28] == 3'b000) cur = w;
  endtask

  task automatic launch(input logic [31:0] base);
    @(negedge clk); n_req = 0; start_we = 1'b1; start_addr = base;
    @(negedge clk); start_we = 1'b0;
    check(busy === 1'b1, "R3", "busy after launch", 32'(busy), 1);
  endtask

  task automatic finish;
    int t = 0;
    bit early = 0;
    wait_req = 1'b1;
    while (busy && t < 5000) begin
      if (wait_ack !== 1'b0) early = 1;
      @(negedge clk); t++;
    end
    check(!early, "R11", "wait_ack while busy", 32'(early), 0);
    check(wait_ack === 1'b1, "R11", "wait_ack when idle", 32'(wait_ack), 1);
    check(cyc == rsp_cyc + 1, "R3", "busy drop cycle", 32'(cyc), 32'(rsp_cyc + 1));
    wait_req = 1'b0;
  endtask

  task automatic expect_xfer(input logic [31:0] base, input string req);
    int len  = (cur[23:20] == 0) ? 16 : int'(cur[23:20]);
    int rows = (cur[19:16] == 0) ? 16 : int'(cur[19:16]);
    int vst  = (cur[15:12] == 0) ? 16 : int'(cur[15:12]);
    int pit  = (cur[27:24] == 0) ? 128 : (8 << cur[27:24]);
    int yr   = int'(cur[10:4]) % 64;
    int x0   = int'(cur[3:0]);
    int k = 0, bad = 0, badp = 0;
    logic [31:0] first_act = '0, first_exp = '0;
    check(n_req == len * rows, "R5", "request count", 32'(n_req), 32'(len * rows));
    for (int r = 0; r < rows; r++) begin
      for (int e = 0; e < len; e++) begin
        logic [31:0] a = base + 32'(r * pit + 4 * e);
        int idx = cur[11] ? (((yr + e) % 64) * 16 + x0) : ((yr * 16 + x0 + e) % 1024);
        if (k < n_req && req_log[k] !== a && bad == 0) begin first_act = req_log[k]; first_exp = a; end
        if (k < n_req && req_log[k] !== a) bad++;
        shadow[idx] = pat(a); sh_vld[idx] = 1;
        k++;
      end
      yr = (yr + vst) % 64;
    end
    check(bad == 0, "R4", "request address", first_act, first_exp);
    for (int i = 0; i < 1024; i++) begin
      if (sh_vld[i]) begin
        rd_row = 6'(i / 16); rd_col = 4'(i % 16); #1;
        if (rd_data !== shadow[i] && badp == 0) begin first_act = rd_data; first_exp = shadow[i]; end
        if (rd_data !== shadow[i]) badp++;
      end
    end
    check(badp == 0, req, "scratchpad contents", first_act, first_exp);
  endtask

  task automatic t_reset;
    #1;
    check(busy === 1'b0, "R1", "busy in reset", 32'(busy), 0);
    check(req_valid === 1'b0, "R1", "req in reset", 32'(req_valid), 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); wait_req = 1'b1; #1;
    check(wait_ack === 1'b1 && busy === 1'b0, "R1", "idle after reset", 32'(wait_ack), 1);
    wait_req = 1'b0;
  endtask

  task automatic t_vectors;
    req_gap = 0; rsp_gap = 0;
    write_setup(32'h8304080F);
    launch(32'h0000_1000);
    finish();
    expect_xfer(32'h0000_1000, "R12 R7");
  endtask

  task automatic t_horizontal;
    req_gap = 2; rsp_gap = 3;
    write_setup(mk(1'b0, 2, 5, 3, 2, 10, 3));
    launch(32'h0002_0040);
    finish();
    expect_xfer(32'h0002_0040, "R8 R6");
  endtask

  task automatic t_reject;
    logic [31:0] keep = cur;
    req_gap = 1; rsp_gap = 0;
    write_setup(32'h0304_080F);
    write_setup(32'h9304_080F);
    check(cur == keep, "R2", "bench setup kept", cur, keep);
    launch(32'h0003_0000);
    finish();
    expect_xfer(32'h0003_0000, "R2");
  endtask

  task automatic t_wraps;
    req_gap = 0; rsp_gap = 1;
    write_setup(mk(1'b0, 0, 4, 2, 1, 63, 14));
    launch(32'h0004_0000);
    finish();
    expect_xfer(32'h0004_0000, "R8 R6");
    write_setup(mk(1'b1, 1, 8, 2, 0, 60, 2));
    launch(32'h0005_0000);
    finish();
    expect_xfer(32'h0005_0000, "R7 R6");
  endtask

  task automatic t_busy_start;
    int n;
    req_gap = 1; rsp_gap = 2;
    write_setup(mk(1'b1, 3, 6, 2, 6, 5, 9));
    launch(32'h0006_0000);
    repeat (4) @(negedge clk);
    start_we = 1'b1; start_addr = 32'hDEAD_0000;
    @(negedge clk); start_we = 1'b0;
    finish();
    expect_xfer(32'h0006_0000, "R10");
    n = n_req;
    repeat (6) @(negedge clk);
    check(busy === 1'b0 && n_req == n, "R10", "no extra transfer", 32'(n_req), 32'(n));
  endtask

  task automatic t_full;
    req_gap = 0; rsp_gap = 0;
    write_setup(mk(1'b1, 6, 0, 0, 1, 0, 0));
    launch(32'h0010_0000);
    finish();
    expect_xfer(32'h0010_0000, "R5 R9");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) sh_vld[i] = 0;
    t_reset();
    t_vectors();
    t_horizontal();
    t_reject();
    t_wraps();
    t_busy_start();
    t_full();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(10 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule